// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a memory-mapped SPI master that carries out a single serial-flash command each time software starts it. Software fills a shared eight-slot byte store through an auto-incrementing data port, sets an opcode and two byte counts, then sets the start bit. The engine lowers chip select and shifts out the opcode. It then sends the requested number of bytes from the store and clocks in the requested number of response bytes into the same store.

Response bytes are put into the slots that follow the transmitted ones. Software resets the store pointer, skips the slots it loaded, and then reads the reply. The store pointer can be read back, so software can confirm that a pointer reset took effect. SPI runs in mode 0, most significant bit first. SCLK comes from the system clock through a fixed even divider.

Register map on the byte bus:

| Offset | Name | Access | Contents |
|---|---|---|---|
| 0x0 | opcode | read/write | command opcode |
| 0x1 | counts | read/write | receive count in [7:4], transmit count in [3:0] |
| 0x2 | control | write: bit 0 = start, bit 4 = pointer reset. read: bit 0 = busy, bit 4 = 0 | |
| 0xC | data port | read/write | byte at the current pointer; the pointer advances by one after each access |
| 0xD | pointer | read only | pointer in [2:0], bits [7:3] read 0 |

Every other offset reads 0.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0 and `spi_mosi` is 0. Offsets 0x0, 0x1, 0x2 and 0xD all read 0.
- R2: After `spi_cs_n` falls, the first byte on `spi_mosi` is the opcode held at offset 0x0. All bytes go out MSB first in SPI mode 0: data changes only while SCLK is low, and it is sampled on the rising edge of SCLK.
- R3: Offset 0x1 holds the receive count in bits [7:4] and the transmit count in bits [3:0]. A command sends exactly 1 + transmit + receive bytes. With both counts at 0, only the opcode is sent and chip select then rises.
- R4: Writing 1 to bit 0 of offset 0x2 starts a command. Bit 0 of offset 0x2 reads 1 from the cycle after the start write until the command ends, and then reads 0 by itself.
- R5: Writing 1 to bit 4 of offset 0x2 sets the store pointer to 0. Each write or read strobe at offset 0xC accesses the slot at the pointer and then advances the pointer by one, modulo 8. Offset 0xD returns the pointer in bits [2:0], with bits [7:3] reading 0.
- R6: The transmit bytes are taken from slots 0 to tx−1 in slot order, so a byte written earlier is sent earlier. The command leaves those slots unchanged.
- R7: Receive byte k is stored in slot (tx + k) mod 8. During the receive phase `spi_mosi` is held at 0.
- R8: While a command runs, writes to offsets 0x0, 0x1 and 0xC have no effect, including no pointer advance. A start request made while busy is also ignored.
- R9: `spi_cs_n` stays low without a break from the opcode through the last receive byte. `spi_sclk` is 0 whenever `spi_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; needed only to advance the data port |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench goes after slot placement. If a design stored response bytes from slot 0, it would overwrite the transmitted address. If it started them one slot late, every reply would come back shifted.

The bench also covers these corner cases, each with the failure it would expose:
- A command with no payload. A design that always ran a payload phase would send a stray byte.
- A full seven-byte transmit. A counter that is too narrow would stop early.
- Writes and a second start while busy. A design that accepted them would corrupt the opcode, the counts or the pointer, or run a second command.
- Pointer wrap past eight accesses. A design that saturated the pointer instead of wrapping would read back the wrong value.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    parameter int unsigned SLOTS   = 8;
    parameter int unsigned SLOT_W  = $clog2(SLOTS);
    parameter int unsigned CNT_W   = 4;
    parameter int unsigned IDX_W   = CNT_W + 1;

    localparam logic [3:0] OFS_OPCODE = 4'h0;
    localparam logic [3:0] OFS_COUNTS = 4'h1;
    localparam logic [3:0] OFS_CTRL   = 4'h2;
    localparam logic [3:0] OFS_DATA   = 4'hC;
    localparam logic [3:0] OFS_PTR    = 4'hD;

    typedef struct packed {
        logic [7:0]             opcode;
        logic [7:0]             counts;
        logic [SLOT_W-1:0]      ptr;
        logic [SLOTS-1:0][7:0]  store;
    } regs_state_t;
endpackage

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              busy,
    output logic              start,
    output logic [7:0]        opcode,
    output logic [CNT_W-1:0]  tx_cnt,
    output logic [CNT_W-1:0]  rx_cnt,
    input  logic [SLOT_W-1:0] eng_rd_idx,
    output logic [7:0]        eng_rd_data,
    input  logic              eng_we,
    input  logic [SLOT_W-1:0] eng_wr_idx,
    input  logic [7:0]        eng_wr_data
);
    regs_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        if (bus_wr) begin
            unique case (bus_addr)
                OFS_OPCODE: if (!busy) st_d.opcode = bus_wdata;
                OFS_COUNTS: if (!busy) st_d.counts = bus_wdata;
                OFS_CTRL: begin
                    if (bus_wdata[4]) st_d.ptr = '0;
                    if (bus_wdata[0] && !busy) start = 1'b1;
                end
                OFS_DATA: if (!busy) begin
                    st_d.store[st_q.ptr] = bus_wdata;
                    st_d.ptr             = st_q.ptr + 1'b1;
                end
                default: ;
            endcase
        end else if (bus_rd && bus_addr == OFS_DATA) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
        if (eng_we) st_d.store[eng_wr_idx] = eng_wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (bus_addr)
            OFS_OPCODE: bus_rdata = st_q.opcode;
            OFS_COUNTS: bus_rdata = st_q.counts;
            OFS_CTRL:   bus_rdata = {7'b0, busy};
            OFS_DATA:   bus_rdata = st_q.store[st_q.ptr];
            OFS_PTR:    bus_rdata = 8'(st_q.ptr);
            default:    bus_rdata = 8'h00;
        endcase
    end

    assign opcode      = st_q.opcode;
    assign tx_cnt      = st_q.counts[CNT_W-1:0];
    assign rx_cnt      = st_q.counts[2*CNT_W-1:CNT_W];
    assign eng_rd_data = st_q.store[eng_rd_idx];
endmodule

// File: rtl/flash_cmd_shifter.sv
module flash_cmd_shifter
    import flash_cmd_pkg::*;
#(
    parameter int unsigned DIV_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [CNT_W-1:0]  tx_cnt,
    input  logic [CNT_W-1:0]  rx_cnt,
    input  logic [7:0]        rd_data,
    output logic [SLOT_W-1:0] rd_idx,
    output logic              we,
    output logic [SLOT_W-1:0] wr_idx,
    output logic [7:0]        wr_data,
    input  logic              spi_miso,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic              spi_cs_n,
    output logic              busy,
    output logic              rx_phase
);
    localparam int unsigned DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(DIV_HALF - 1);

    typedef struct packed {
        logic             busy;
        logic             sclk;
        logic             cs_n;
        logic [DW-1:0]    div;
        logic [2:0]       bitn;
        logic [IDX_W-1:0] byte_idx;
        logic [IDX_W-1:0] total;
        logic [CNT_W-1:0] txc;
        logic [7:0]       shreg;
        logic [7:0]       rxsr;
    } eng_state_t;

    eng_state_t e_d, e_q;
    logic [IDX_W-1:0] next_idx;

    assign next_idx = e_q.byte_idx + 1'b1;

    always_comb begin
        e_d = e_q;
        we  = 1'b0;
        if (!e_q.busy) begin
            if (start) begin
                e_d.busy     = 1'b1;
                e_d.cs_n     = 1'b0;
                e_d.sclk     = 1'b0;
                e_d.div      = '0;
                e_d.bitn     = '0;
                e_d.byte_idx = '0;
                e_d.total    = IDX_W'(1) + IDX_W'(tx_cnt) + IDX_W'(rx_cnt);
                e_d.txc      = tx_cnt;
                e_d.shreg    = opcode;
            end
        end else if (e_q.div == DIV_LAST) begin
            e_d.div  = '0;
            e_d.sclk = ~e_q.sclk;
            if (!e_q.sclk) begin
                e_d.rxsr = {e_q.rxsr[6:0], spi_miso};
            end else begin
                e_d.shreg = {e_q.shreg[6:0], 1'b0};
                e_d.bitn  = e_q.bitn + 1'b1;
                if (e_q.bitn == 3'd7) begin
                    if (e_q.byte_idx > IDX_W'(e_q.txc)) we = 1'b1;
                    e_d.byte_idx = next_idx;
                    if (next_idx == e_q.total) begin
                        e_d.busy = 1'b0;
                        e_d.cs_n = 1'b1;
                    end else if (next_idx <= IDX_W'(e_q.txc)) begin
                        e_d.shreg = rd_data;
                    end else begin
                        e_d.shreg = 8'h00;
                    end
                end
            end
        end else begin
            e_d.div = e_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q      <= '0;
            e_q.cs_n <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    assign rd_idx   = e_q.byte_idx[SLOT_W-1:0];
    assign wr_idx   = e_q.byte_idx[SLOT_W-1:0] - 1'b1;
    assign wr_data  = e_q.rxsr;
    assign spi_sclk = e_q.sclk;
    assign spi_cs_n = e_q.cs_n;
    assign spi_mosi = e_q.busy & e_q.shreg[7];
    assign busy     = e_q.busy;
    assign rx_phase = e_q.busy && (e_q.byte_idx > IDX_W'(e_q.txc));
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
    import flash_cmd_pkg::*;
#(
    parameter int unsigned DIV_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       spi_sclk,
    output logic       spi_mosi,
    output logic       spi_cs_n,
    input  logic       spi_miso
);
    logic              busy, start, rx_phase, eng_we;
    logic [7:0]        opcode, eng_rd_data, eng_wr_data;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic [SLOT_W-1:0] eng_rd_idx, eng_wr_idx;

    flash_cmd_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .start(start), .opcode(opcode),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .eng_rd_idx(eng_rd_idx), .eng_rd_data(eng_rd_data),
        .eng_we(eng_we), .eng_wr_idx(eng_wr_idx), .eng_wr_data(eng_wr_data)
    );

    flash_cmd_shifter #(.DIV_HALF(DIV_HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .rd_data(eng_rd_data), .rd_idx(eng_rd_idx),
        .we(eng_we), .wr_idx(eng_wr_idx), .wr_data(eng_wr_data),
        .spi_miso(spi_miso), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .busy(busy), .rx_phase(rx_phase)
    );
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_sclk,
    input logic       spi_mosi,
    input logic [3:0] bus_addr,
    input logic [7:0] bus_rdata,
    input logic       busy,
    input logic       rx_phase,
    input logic [7:0] opcode
);
    a_r9_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    a_r2_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> $stable(spi_mosi));

    a_r7_mosi_low_rx: assert property (@(posedge clk) disable iff (!rst_n)
        rx_phase |-> !spi_mosi);

    a_r8_opcode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(opcode));

    a_r5_ptr_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 4'hD) |-> (bus_rdata[7:3] == 5'd0));

    a_r9_cs_rise_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> !spi_sclk);
endmodule

bind flash_cmd_engine flash_cmd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .busy(busy), .rx_phase(rx_phase), .opcode(opcode)
);

// File: tb/flash_cmd_engine_bench.sv
`timescale 1ns/1ps
module flash_cmd_engine_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       spi_sclk, spi_mosi, spi_cs_n, spi_miso;

    int nchk = 0;
    int nbad = 0;

    always #2.5 clk = ~clk;

    flash_cmd_engine u_flash_cmd_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
        .spi_miso(spi_miso)
    );

    function automatic logic [7:0] resp(input int n);
        logic [7:0] t;
        t = 8'(n) * 8'd19;
        return 8'h5A ^ t;
    endfunction

    // flash model: records MOSI bytes, answers with resp(byte number)
    int         bc = 0;
    int         cap_n = 0;
    logic [7:0] sr = 8'h00;
    logic [7:0] cap [32];

    always @(posedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            cap_n = bc / 8;
            bc    = 0;
        end else begin
            sr = {sr[6:0], spi_mosi};
            if (bc % 8 == 7) cap[(bc / 8) % 32] = sr;
            bc = bc + 1;
        end
    end

    logic [7:0] cur_resp;
    assign cur_resp = resp(bc / 8);
    assign spi_miso = cur_resp[3'(7 - (bc % 8))];

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        v = 8'h01;
        for (int i = 0; i < 2000 && v[0]; i++) rd(4'h2, v);
        check("R4 busy self-clear", int'(v[0]), 0);
        repeat (4) @(negedge clk);
    endtask

    // {opcode, tx, rx, 7 tx bytes with byte j at [8j+:8]}
    localparam int NV = 7;
    localparam logic [71:0] VEC [NV] = '{
        {8'h06, 4'd0, 4'd0, 56'h0},
        {8'h05, 4'd0, 4'd1, 56'h0},
        {8'h90, 4'd3, 4'd2, 56'h000000},
        {8'h20, 4'd3, 4'd0, 56'h563412},
        {8'h02, 4'd7, 4'd0, 56'hDEADBEEF563412},
        {8'h9F, 4'd0, 4'd3, 56'h0},
        {8'h0B, 4'd4, 4'd4, 56'h00030201}
    };

    initial begin : watchdog
        #(5.0 * 150000);
        nbad++;
        $display("FAIL R4 watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] op;
        int tx, rx;
        logic [55:0] dat;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cs_n", int'(spi_cs_n), 1);
        check("R1 sclk", int'(spi_sclk), 0);
        check("R1 mosi", int'(spi_mosi), 0);
        rst_n = 1'b1;
        rd(4'h0, v); check("R1 opcode reg", int'(v), 0);
        rd(4'h1, v); check("R1 counts reg", int'(v), 0);
        rd(4'h2, v); check("R1 control reg", int'(v), 0);
        rd(4'hD, v); check("R1 pointer reg", int'(v), 0);

        for (int n = 0; n < NV; n++) begin
            op  = VEC[n][71:64];
            tx  = int'(VEC[n][63:60]);
            rx  = int'(VEC[n][59:56]);
            dat = VEC[n][55:0];
            wr(4'h2, 8'h10);
            for (int j = 0; j < tx; j++) wr(4'hC, dat[8*j +: 8]);
            wr(4'h0, op);
            wr(4'h1, {4'(rx), 4'(tx)});
            wr(4'h2, 8'h01);
            rd(4'h2, v); check("R4 busy reads 1", int'(v[0]), 1);
            wait_idle();
            check("R3 byte count", cap_n, 1 + tx + rx);
            check("R2 opcode first", int'(cap[0]), int'(op));
            for (int j = 0; j < tx; j++)
                check("R6 tx byte order", int'(cap[1 + j]), int'(dat[8*j +: 8]));
            for (int j = 0; j < rx; j++)
                check("R7 mosi low in rx", int'(cap[1 + tx + j]), 0);
            wr(4'h2, 8'h10);
            rd(4'hD, v); check("R5 pointer reset", int'(v), 0);
            for (int s = 0; s < tx + rx; s++) begin
                rd(4'hC, v);
                if (s < tx) check("R6 tx slot kept", int'(v), int'(dat[8*s +: 8]));
                else        check("R7 rx slot", int'(v), int'(resp(s + 1)));
            end
            check("R9 cs high after", int'(spi_cs_n), 1);
        end

        // R5 pointer wraps modulo 8 and upper bits read 0
        wr(4'h2, 8'h10);
        for (int j = 0; j < 9; j++) wr(4'hC, 8'(j));
        rd(4'hD, v); check("R5 pointer wrap", int'(v), 1);
        wr(4'h2, 8'h10);
        rd(4'hC, v); check("R5 wrapped slot0 overwritten", int'(v), 8);

        // R8 writes and start while busy are ignored
        wr(4'h2, 8'h10);
        wr(4'h0, 8'h3C);
        wr(4'h1, 8'h30);
        wr(4'h2, 8'h01);
        wr(4'h0, 8'hFF);
        wr(4'h1, 8'h00);
        wr(4'hC, 8'hAA);
        wr(4'h2, 8'h01);
        wait_idle();
        check("R8 single command", cap_n, 4);
        rd(4'h0, v); check("R8 opcode unchanged", int'(v), 8'h3C);
        rd(4'h1, v); check("R8 counts unchanged", int'(v), 8'h30);
        rd(4'hD, v); check("R8 pointer unchanged", int'(v), 0);
        rd(4'hC, v); check("R7 rx slot0 tx0", int'(v), int'(resp(1)));
        repeat (40) @(negedge clk);
        check("R8 no restart", int'(spi_cs_n), 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule